// File: doc/BRIEF.md
# Basic-Block Configuration Builder

This block sits beside a processor core and watches the stream of retired instructions. It groups consecutive instructions into configurations for a coarse-grained array made of levels. Each level holds rows of chained ALUs plus a few multiplier and memory units. For every instruction it decodes the operand registers and checks them against the instructions already placed in the configuration being built. It then chooses a level and a unit, and writes the placement out to a reconfiguration memory port.

A configuration ends on a branch, on an unsupported instruction, or when no unit can take the next operation. The instruction that ends it is never placed. If the configuration holds enough instructions, a lookup-cache entry is written for it, carrying its start address, its identifier and its length. Otherwise the configuration is dropped and its identifier is used again. The block has four register stages: decode, dependence check, allocation and table write. It accepts one instruction per cycle, and a dependent instruction may follow its producer directly.

Top module: `cfg_builder`

## Requirements
- R1: While reset is asserted and in the cycles after it is released, no configuration write and no cache write is issued, and the first configuration identifier is 0.
- R2: The result for an instruction sampled at a rising edge appears on the output ports after the fourth rising edge that follows it. The result is a placement write (cfg_we) or a cache write (cache_we), and the cycles in between are idle.
- R3: Opcode 0 is ALU, 1 is multiply, 2 is memory, 3 is branch, and 4 to 7 are unsupported. Register 0 as a source never creates a dependence. An instruction whose destination is register 0 is placed but records no producer.
- R4: An ALU operation with no producer in the current configuration goes to the lowest level, and within it to the lowest row, that has a free chain slot. The reported slot is the number of operations already in that row (cfg_kind 0, cfg_col is the row).
- R5: An ALU operation whose ALU producers sit in level p chains in level p, in the row of those producers, if that row has a free slot. If the producers in level p are in different rows, or the row is full, the operation goes to a later level, in any row.
- R6: An operation goes at least one level after every multiply or memory producer. A multiply or memory operation also goes at least one level after every ALU producer.
- R7: A multiply or memory operation takes the lowest allowed level with a free unit of its type (cfg_kind 1 or 2). cfg_col is the number of units of that type already used in that level, and cfg_slot is 0.
- R8: A branch or unsupported instruction closes the configuration and is not written. The instructions after it see no producers from the closed configuration.
- R9: An operation that finds no free unit in any allowed level closes the configuration exactly like an unsupported instruction, and is itself dropped.
- R10: Closing a configuration of three or more instructions writes one cache entry. The entry carries the address of the first placed instruction, the configuration identifier and the instruction count, and the identifier then advances by one.
- R11: Closing a configuration of fewer than three instructions writes no cache entry, and the next configuration reuses the same identifier.
- R12: Placement writes number the instructions of a configuration 0, 1, 2 and so on in arrival order, and carry the current identifier and the destination and source registers.
- R13: An instruction that directly follows its producer, or the instruction that closed a configuration, is placed by the same rules as one that arrives later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A retired instruction is present |
| in_op | input | 3 | Operation class code |
| in_pc | input | PCW | Instruction address |
| in_rd | input | RW | Destination register |
| in_rs1 | input | RW | First source register |
| in_rs2 | input | RW | Second source register |
| cfg_we | output | 1 | Placement write strobe |
| cfg_id | output | IDW | Configuration identifier |
| cfg_idx | output | NW | Instruction index within the configuration |
| cfg_kind | output | 2 | Unit type: 0 ALU, 1 multiply, 2 memory |
| cfg_level | output | LW | Level of the chosen unit |
| cfg_col | output | CW | Row (ALU) or unit index (multiply, memory) |
| cfg_slot | output | SW | Chain slot in the row (ALU) |
| cfg_dst | output | RW | Destination register |
| cfg_src1 | output | RW | First source register |
| cfg_src2 | output | RW | Second source register |
| cache_we | output | 1 | Cache entry write strobe |
| cache_pc | output | PCW | Start address of the closed configuration |
| cache_id | output | IDW | Identifier of the closed configuration |
| cache_len | output | NW | Instruction count of the closed configuration |

## Verification
Every instruction produces at most one output event: a placement write, a cache write, or nothing. That event is due after the fourth rising edge following the edge that samples the instruction, whether the instruction is placed or closes the configuration. The bench drives on falling edges and notes the due cycle of each expected event. It compares outputs on falling edges and flags any event that comes early, late or unannounced as an R2 failure. Directed sequences cover each placement rule and each way a configuration can close, on back-to-back instructions. A long pseudo-random stream then checks the rules where they interact.

// File: rtl/cfg_builder.sv
module cfg_builder #(
  parameter int REGS   = 16,
  parameter int LEVELS = 4,
  parameter int ROWS   = 2,
  parameter int CHAIN  = 3,
  parameter int NMUL   = 1,
  parameter int NMEM   = 1,
  parameter int MINLEN = 3,
  parameter int PCW    = 16,
  parameter int IDW    = 4,
  localparam int RW = $clog2(REGS),
  localparam int LW = $clog2(LEVELS),
  localparam int CW = $clog2(ROWS + NMUL + NMEM),
  localparam int SW = $clog2(CHAIN + 1),
  localparam int NW = $clog2(LEVELS * (ROWS * CHAIN + NMUL + NMEM) + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [2:0]     in_op,
  input  logic [PCW-1:0] in_pc,
  input  logic [RW-1:0]  in_rd,
  input  logic [RW-1:0]  in_rs1,
  input  logic [RW-1:0]  in_rs2,
  output logic           cfg_we,
  output logic [IDW-1:0] cfg_id,
  output logic [NW-1:0]  cfg_idx,
  output logic [1:0]     cfg_kind,
  output logic [LW-1:0]  cfg_level,
  output logic [CW-1:0]  cfg_col,
  output logic [SW-1:0]  cfg_slot,
  output logic [RW-1:0]  cfg_dst,
  output logic [RW-1:0]  cfg_src1,
  output logic [RW-1:0]  cfg_src2,
  output logic           cache_we,
  output logic [PCW-1:0] cache_pc,
  output logic [IDW-1:0] cache_id,
  output logic [NW-1:0]  cache_len
);

  logic           d_v, d_cl;
  logic [1:0]     d_k;
  logic [PCW-1:0] d_pc;
  logic [RW-1:0]  d_rd;
  logic [RW-1:0]  d_s [2];

  always_ff @(posedge clk) begin
    if (!rst_n) d_v <= 1'b0;
    else begin
      d_v    <= in_valid;
      d_cl   <= in_op >= 3'd3;
      d_k    <= (in_op >= 3'd3) ? 2'd0 : in_op[1:0];
      d_pc   <= in_pc;
      d_rd   <= in_rd;
      d_s[0] <= in_rs1;
      d_s[1] <= in_rs2;
    end
  end

  logic [REGS-1:0] tv, ta;
  logic [LW-1:0]   tl [REGS];
  logic [CW-1:0]   tr [REGS];
  logic [SW-1:0]   fill [LEVELS][ROWS];
  logic [CW-1:0]   mu [LEVELS];
  logic [CW-1:0]   me [LEVELS];
  logic [NW-1:0]   cnt;
  logic [PCW-1:0]  spc;
  logic [IDW-1:0]  idq;

  logic           v_v, v_cl;
  logic [1:0]     v_k;
  logic [PCW-1:0] v_pc;
  logic [RW-1:0]  v_rd;
  logic [RW-1:0]  v_s [2];
  logic [1:0]     v_pv, v_pa;
  logic [LW-1:0]  v_pl [2];
  logic [CW-1:0]  v_pr [2];

  logic          fit, a_place, a_close, creq, cconf;
  logic [CW-1:0] crow;
  logic [LW-1:0] p_lvl;
  logic [CW-1:0] p_col;
  logic [SW-1:0] p_slot;
  int            need, n;

  always_comb begin
    need = 0; n = 0; creq = 1'b0; cconf = 1'b0; crow = '0;
    for (int s = 0; s < 2; s++) begin
      if (v_pv[s]) begin
        n = (v_k == 2'd0 && v_pa[s]) ? int'(v_pl[s]) : int'(v_pl[s]) + 1;
        if (n > need) need = n;
      end
    end
    for (int s = 0; s < 2; s++) begin
      if (v_pv[s] && v_pa[s] && v_k == 2'd0 && int'(v_pl[s]) == need) begin
        if (creq && crow != v_pr[s]) cconf = 1'b1;
        creq = 1'b1;
        crow = v_pr[s];
      end
    end
    fit = 1'b0; p_lvl = '0; p_col = '0; p_slot = '0;
    for (int l = LEVELS - 1; l >= 0; l--) begin
      if (l >= need) begin
        if (v_k == 2'd0) begin
          for (int r = ROWS - 1; r >= 0; r--) begin
            if (fill[l][r] < SW'(CHAIN) && !(l == need && creq && (cconf || CW'(r) != crow))) begin
              fit = 1'b1; p_lvl = LW'(l); p_col = CW'(r); p_slot = fill[l][r];
            end
          end
        end else if (v_k == 2'd1) begin
          if (mu[l] < CW'(NMUL)) begin
            fit = 1'b1; p_lvl = LW'(l); p_col = mu[l]; p_slot = '0;
          end
        end else begin
          if (me[l] < CW'(NMEM)) begin
            fit = 1'b1; p_lvl = LW'(l); p_col = me[l]; p_slot = '0;
          end
        end
      end
    end
  end

  assign a_place = v_v && !v_cl && fit;
  assign a_close = v_v && (v_cl || !fit);

  logic [1:0]    f_pv, f_pa;
  logic [LW-1:0] f_pl [2];
  logic [CW-1:0] f_pr [2];

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      f_pv[s] = 1'b0; f_pa[s] = 1'b0; f_pl[s] = '0; f_pr[s] = '0;
      if (d_s[s] != '0 && !a_close) begin
        if (a_place && v_rd == d_s[s]) begin
          f_pv[s] = 1'b1; f_pa[s] = (v_k == 2'd0); f_pl[s] = p_lvl; f_pr[s] = p_col;
        end else begin
          f_pv[s] = tv[d_s[s]]; f_pa[s] = ta[d_s[s]]; f_pl[s] = tl[d_s[s]]; f_pr[s] = tr[d_s[s]];
        end
      end
    end
  end

  logic           a_we, a_ce;
  logic [IDW-1:0] a_id;
  logic [NW-1:0]  a_idx;
  logic [1:0]     a_k;
  logic [LW-1:0]  a_lvl;
  logic [CW-1:0]  a_col;
  logic [SW-1:0]  a_slot;
  logic [RW-1:0]  a_rd, a_s1, a_s2;
  logic [PCW-1:0] a_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_v <= 1'b0; tv <= '0; cnt <= '0; idq <= '0; a_we <= 1'b0; a_ce <= 1'b0;
      for (int l = 0; l < LEVELS; l++) begin
        mu[l] <= '0; me[l] <= '0;
        for (int r = 0; r < ROWS; r++) fill[l][r] <= '0;
      end
    end else begin
      v_v <= d_v; v_cl <= d_cl; v_k <= d_k; v_pc <= d_pc; v_rd <= d_rd;
      v_s <= d_s; v_pv <= f_pv; v_pa <= f_pa; v_pl <= f_pl; v_pr <= f_pr;
      if (a_close) begin
        tv <= '0; cnt <= '0;
        if (cnt >= NW'(MINLEN)) idq <= idq + 1'b1;
        for (int l = 0; l < LEVELS; l++) begin
          mu[l] <= '0; me[l] <= '0;
          for (int r = 0; r < ROWS; r++) fill[l][r] <= '0;
        end
      end else if (a_place) begin
        if (v_rd != '0) begin
          tv[v_rd] <= 1'b1; ta[v_rd] <= (v_k == 2'd0); tl[v_rd] <= p_lvl; tr[v_rd] <= p_col;
        end
        if (v_k == 2'd0) fill[p_lvl][p_col] <= p_slot + 1'b1;
        else if (v_k == 2'd1) mu[p_lvl] <= p_col + 1'b1;
        else me[p_lvl] <= p_col + 1'b1;
        cnt <= cnt + 1'b1;
        if (cnt == '0) spc <= v_pc;
      end
      a_we <= a_place; a_ce <= a_close && cnt >= NW'(MINLEN);
      a_id <= idq; a_idx <= cnt; a_k <= v_k; a_lvl <= p_lvl; a_col <= p_col; a_slot <= p_slot;
      a_rd <= v_rd; a_s1 <= v_s[0]; a_s2 <= v_s[1]; a_pc <= spc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_we <= 1'b0; cache_we <= 1'b0;
    end else begin
      cfg_we <= a_we; cfg_id <= a_id; cfg_idx <= a_idx; cfg_kind <= a_k; cfg_level <= a_lvl;
      cfg_col <= a_col; cfg_slot <= a_slot; cfg_dst <= a_rd; cfg_src1 <= a_s1; cfg_src2 <= a_s2;
      cache_we <= a_ce; cache_pc <= a_pc; cache_id <= a_id; cache_len <= a_idx;
    end
  end

endmodule

// File: rtl/cfg_builder_chk.sv
module cfg_builder_chk #(
  parameter int ROWS = 2, CHAIN = 3, NMUL = 1, NMEM = 1, MINLEN = 3,
  parameter int IDW = 4, CW = 2, SW = 2, NW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_we,
  input logic [1:0]     cfg_kind,
  input logic [CW-1:0]  cfg_col,
  input logic [SW-1:0]  cfg_slot,
  input logic           cache_we,
  input logic [IDW-1:0] cache_id,
  input logic [NW-1:0]  cache_len,
  input logic [IDW-1:0] idq
);
  AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !(cfg_we && cache_we)); // R8
  AST_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n) cache_we |-> cache_len >= NW'(MINLEN)); // R11
  AST_ID_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) cache_we |-> idq == cache_id + 1'b1); // R10
  AST_ALU_SLOT: assert property (@(posedge clk) disable iff (!rst_n) (cfg_we && cfg_kind == 2'd0) |-> (cfg_slot < SW'(CHAIN) && cfg_col < CW'(ROWS))); // R4
  AST_MUL_UNIT: assert property (@(posedge clk) disable iff (!rst_n) (cfg_we && cfg_kind == 2'd1) |-> (cfg_col < CW'(NMUL) && cfg_slot == '0)); // R7
  AST_MEM_UNIT: assert property (@(posedge clk) disable iff (!rst_n) (cfg_we && cfg_kind == 2'd2) |-> (cfg_col < CW'(NMEM) && cfg_slot == '0)); // R7
  AST_KIND_CODE: assert property (@(posedge clk) disable iff (!rst_n) cfg_we |-> cfg_kind != 2'd3); // R3
endmodule

bind cfg_builder cfg_builder_chk #(
  .ROWS(ROWS), .CHAIN(CHAIN), .NMUL(NMUL), .NMEM(NMEM), .MINLEN(MINLEN),
  .IDW(IDW), .CW(CW), .SW(SW), .NW(NW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_col(cfg_col),
  .cfg_slot(cfg_slot), .cache_we(cache_we), .cache_id(cache_id), .cache_len(cache_len), .idq(idq)
);

// File: tb/cfg_builder_bench.sv
module cfg_builder_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, in_valid;
  logic [2:0]  in_op;
  logic [15:0] in_pc;
  logic [3:0]  in_rd, in_rs1, in_rs2;
  logic        cfg_we, cache_we;
  logic [3:0]  cfg_id, cfg_dst, cfg_src1, cfg_src2, cache_id;
  logic [5:0]  cfg_idx, cache_len;
  logic [1:0]  cfg_kind, cfg_level, cfg_col, cfg_slot;
  logic [15:0] cache_pc;

  cfg_builder u_cfg_builder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_pc(in_pc),
    .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2), .cfg_we(cfg_we), .cfg_id(cfg_id),
    .cfg_idx(cfg_idx), .cfg_kind(cfg_kind), .cfg_level(cfg_level), .cfg_col(cfg_col),
    .cfg_slot(cfg_slot), .cfg_dst(cfg_dst), .cfg_src1(cfg_src1), .cfg_src2(cfg_src2),
    .cache_we(cache_we), .cache_pc(cache_pc), .cache_id(cache_id), .cache_len(cache_len)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  logic [63:0] e_w [8192];
  int          e_due [8192];
  string       e_tag [8192];
  int eh = 0, et = 0;
  string tag = "R1";

  bit mv [16]; bit ma [16]; int ml [16]; int mr [16];
  int mf [4][2]; int mm [4]; int mx [4];
  int mcnt = 0, mid = 0, mspc = 0, pc = 0;

  task automatic push(logic [63:0] w, int due);
    e_w[et] = w; e_due[et] = due; e_tag[et] = tag; et++;
  endtask

  task automatic m_close(int due);
    if (mcnt >= 3) begin
      push({1'b1, 37'b0, 16'(mspc), 4'(mid), 6'(mcnt)}, due);
      mid = (mid + 1) % 16;
    end
    mcnt = 0;
    for (int i = 0; i < 16; i++) mv[i] = 0;
    for (int l = 0; l < 4; l++) begin
      mm[l] = 0; mx[l] = 0; mf[l][0] = 0; mf[l][1] = 0;
    end
  endtask

  function automatic bit src_ok(int s, int l, int r, bit alu);
    if (s == 0 || !mv[s]) return 1;
    if (alu && ma[s]) return (l > ml[s]) || (l == ml[s] && r == mr[s]);
    return l > ml[s];
  endfunction

  task automatic m_step(int op, int ipc, int rd, int s1, int s2, int due);
    bit found = 0;
    int fl = 0, fc = 0, fs = 0;
    if (op >= 3) begin m_close(due); return; end
    for (int l = 0; l < 4; l++) begin
      if (!found) begin
        if (op == 0) begin
          for (int r = 0; r < 2; r++)
            if (!found && mf[l][r] < 3 && src_ok(s1, l, r, 1) && src_ok(s2, l, r, 1)) begin
              found = 1; fl = l; fc = r; fs = mf[l][r];
            end
        end else if (op == 1) begin
          if (mm[l] < 1 && src_ok(s1, l, 0, 0) && src_ok(s2, l, 0, 0)) begin found = 1; fl = l; fc = mm[l]; end
        end else begin
          if (mx[l] < 1 && src_ok(s1, l, 0, 0) && src_ok(s2, l, 0, 0)) begin found = 1; fl = l; fc = mx[l]; end
        end
      end
    end
    if (!found) begin m_close(due); return; end
    push({34'b0, 4'(mid), 6'(mcnt), 2'(op), 2'(fl), 2'(fc), 2'(fs), 4'(rd), 4'(s1), 4'(s2)}, due);
    if (op == 0) mf[fl][fc]++; else if (op == 1) mm[fl]++; else mx[fl]++;
    if (rd != 0) begin mv[rd] = 1; ma[rd] = (op == 0); ml[rd] = fl; mr[rd] = fc; end
    if (mcnt == 0) mspc = ipc;
    mcnt++;
  endtask

  task automatic send(int op, int rd, int s1, int s2);
    @(negedge clk);
    in_valid = 1'b1; in_op = 3'(op); in_pc = 16'(pc); in_rd = 4'(rd); in_rs1 = 4'(s1); in_rs2 = 4'(s2);
    m_step(op, pc, rd, s1, s2, cyc + 4);
    pc = (pc + 4) % 65536;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) begin @(negedge clk); in_valid = 1'b0; end
  endtask

  always @(negedge clk) begin
    logic [63:0] act;
    if (rst_n === 1'b1) begin
      if (cfg_we || cache_we) begin
        act = cache_we ? {1'b1, 37'b0, cache_pc, cache_id, cache_len}
                       : {34'b0, cfg_id, cfg_idx, cfg_kind, cfg_level, cfg_col, cfg_slot, cfg_dst, cfg_src1, cfg_src2};
        checks++;
        if (eh < et && e_due[eh] == cyc) begin
          if (act != e_w[eh]) begin
            failures++;
            $display("FAIL %s cycle %0d actual=%h expected=%h", e_tag[eh], cyc, act, e_w[eh]);
          end
          eh++;
        end else begin
          failures++;
          $display("FAIL R2 cycle %0d actual=%h expected=no event", cyc, act);
        end
      end else if (eh < et && e_due[eh] <= cyc) begin
        checks++; failures++;
        $display("FAIL R2 cycle %0d actual=no event expected=%h (%s)", cyc, e_w[eh], e_tag[eh]);
        eh++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    int r;
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_pc = '0; in_rd = '0; in_rs1 = '0; in_rs2 = '0;
    m_close(0);
    repeat (3) @(negedge clk);
    checks++;
    if (cfg_we !== 1'b0 || cache_we !== 1'b0) begin
      failures++; $display("FAIL R1 actual=%b%b expected=00", cfg_we, cache_we);
    end
    rst_n = 1'b1;
    idle(3);
    checks++;
    if (cfg_we !== 1'b0 || cache_we !== 1'b0) begin
      failures++; $display("FAIL R1 actual=%b%b expected=00", cfg_we, cache_we);
    end

    tag = "R4";
    for (int i = 1; i <= 7; i++) send(0, i, 0, 0);
    tag = "R10"; send(3, 0, 0, 0);

    tag = "R5";
    send(0, 1, 0, 0); send(0, 2, 1, 0); send(0, 3, 2, 0); send(0, 4, 3, 0);
    send(0, 5, 0, 0); send(0, 6, 4, 5); send(0, 7, 5, 0); send(0, 8, 3, 7);
    tag = "R10"; send(3, 0, 0, 0);

    tag = "R6";
    send(0, 1, 0, 0); send(1, 2, 1, 0); send(0, 3, 2, 0); send(2, 4, 3, 0);
    tag = "R9"; send(0, 5, 4, 0);
    tag = "R8"; send(0, 6, 4, 0);
    tag = "R11"; send(3, 0, 0, 0);

    tag = "R7";
    for (int i = 1; i <= 5; i++) send(1, i, 0, 0);
    send(2, 1, 0, 0); send(2, 2, 1, 0);
    tag = "R9";
    for (int i = 0; i < 4; i++) send(2, 3 + i, 0, 0);
    send(7, 0, 0, 0);

    tag = "R3";
    send(0, 0, 0, 0); send(0, 1, 0, 0); send(0, 2, 1, 0); send(0, 3, 0, 2);
    send(5, 0, 0, 0);

    tag = "R11";
    send(0, 1, 0, 0); send(0, 2, 1, 0); send(3, 0, 0, 0);
    tag = "R12";
    send(0, 1, 0, 0); send(1, 2, 1, 1); send(2, 0, 2, 1); send(4, 0, 0, 0);
    idle(2);

    tag = "R13";
    lf = 32'h1234_5678;
    for (int i = 0; i < 6000; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      r = int'(lf[3:0]);
      if (r <= 8) send(0, int'(lf[6:4]), int'(lf[9:7]), int'(lf[12:10]));
      else if (r <= 10) send(1, int'(lf[6:4]), int'(lf[9:7]), int'(lf[12:10]));
      else if (r <= 12) send(2, int'(lf[6:4]), int'(lf[9:7]), int'(lf[12:10]));
      else if (r == 13) send(3, 0, 0, 0);
      else if (r == 14) send(4 + int'(lf[5:4]), 0, 0, 0);
      else idle(1);
    end
    send(3, 0, 0, 0);
    idle(10);
    checks++;
    if (eh != et) begin
      failures++; $display("FAIL R2 actual=%0d events expected=%0d events", eh, et);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule